// File: doc/BRIEF.md
# Programmable Waveform Bus Master

This block masters an external parallel bus by stepping through a small table of waveform vectors that a host loads beforehand. Each vector drives three control lines and holds until a programmable condition on two ready inputs is met. On the cycle the condition is met, the vector can pulse a FIFO advance, bump the bus address and pick the next vector. A chain of vectors that ends in a terminal vector forms one complete bus transaction.

The host loads the table through a simple write port. It then sets the base address, the FIFO select, the bus width and a wait timeout, and pulses `start_i`. The block reports the end of the transaction with a one-cycle `done_o`. A wait step that stalls too long aborts the transaction and raises `err_o`. Any protocol is built by programming the table.

Vector word layout (15 bits): `[2:0]` control levels, `[4:3]` ready mask, `[6:5]` required ready levels, `[7]` combine (1 = OR, 0 = AND), `[8]` FIFO advance, `[9]` address increment, `[10]` direction (1 = drive bus from FIFO, 0 = capture bus into FIFO), `[11]` terminal, `[14:12]` next vector index.

Top module: `wave_master`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, err_o, fifo_adv_o and bus_oe_o are low, and ctl_o and fifo_sel_o are zero.
- R2: A start_i pulse while idle begins execution at vector 0, raises busy_o, and captures addr_base_i into addr_o and fifo_sel_i into fifo_sel_o. fifo_sel_o holds the captured value until the next start.
- R3: While busy, ctl_o equals bits [2:0] of the current vector. While idle, ctl_o is zero.
- R4: Bit 3 of the ready mask word enables rdy_i[0] and bit 4 enables rdy_i[1]. The level each enabled input must show is given by bits 5 and 6 respectively. With bit 7 set, any enabled match satisfies the vector; with bit 7 clear, all enabled inputs must match. An empty mask is satisfied at once. The machine stays on the vector until it is satisfied.
- R5: In the cycle a vector is satisfied, fifo_adv_o is high if bit 8 is set. If bit 9 is set, addr_o is one higher from the next cycle on.
- R6: A vector with bit 10 set drives bus_oe_o high and presents fifo_rdata_i on bus_dout_o. With bit 10 clear, bus_oe_o is low and fifo_wdata_o carries bus_din_i. When bus_16_i is low, the upper byte of both data paths reads zero.
- R7: A satisfied non-terminal vector passes control to the vector indexed by bits [14:12]. A satisfied vector with bit 11 set ends the transaction: done_o is high for exactly one cycle, and busy_o falls in that same cycle.
- R8: With timeout_i nonzero, a vector left unsatisfied for timeout_i+1 consecutive cycles aborts the transaction: busy_o falls, err_o rises, and done_o stays low. err_o stays high until the next start. With timeout_i zero, the machine waits without limit.
- R9: start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Vector table write strobe |
| cfg_addr_i | input | 3 | Vector table write index |
| cfg_data_i | input | 15 | Vector word to write |
| start_i | input | 1 | Begin a transaction |
| bus_16_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| fifo_sel_i | input | 2 | FIFO select to use for the transaction |
| addr_base_i | input | ADDR_W | Starting bus address |
| timeout_i | input | TO_W | Wait limit in cycles, 0 = none |
| rdy_i | input | 2 | Ready inputs |
| fifo_rdata_i | input | DATA_W | FIFO head word to drive out |
| bus_din_i | input | DATA_W | Data bus input |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout abort flag |
| ctl_o | output | 3 | Control outputs |
| fifo_sel_o | output | 2 | FIFO select driven by the master |
| addr_o | output | ADDR_W | Bus address |
| fifo_adv_o | output | 1 | FIFO advance strobe |
| fifo_wdata_o | output | DATA_W | Captured bus data toward the FIFO |
| bus_dout_o | output | DATA_W | Data bus output |
| bus_oe_o | output | 1 | Data bus output enable |

## Verification
The bench goes after the timeout boundary. A wait satisfied on its timeout_i+1-th cycle must complete, and one never satisfied must abort. An off-by-one counter would either fail the first run or let the second run on. Polarity and the AND/OR combine are exercised with mixed ready levels, where swapping the combine or ignoring the polarity makes the machine leave a vector early or hang on it. A non-sequential jump chain catches a design that simply increments the index. Start pulses and select changes during a wait catch a master that restarts mid-transaction or lets fifo_sel_o follow its input. The 8-bit mode checks that the upper byte is masked.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int NUM_VEC = 8;
  localparam int IDX_W   = $clog2(NUM_VEC);
  localparam int CTL_W   = 3;
  localparam int RDY_W   = 2;

  typedef struct packed {
    logic [IDX_W-1:0] nxt;
    logic             last;
    logic             drive;
    logic             inc;
    logic             adv;
    logic             comb_or;
    logic [RDY_W-1:0] pol;
    logic [RDY_W-1:0] mask;
    logic [CTL_W-1:0] ctl;
  } vec_t;

  localparam int VEC_W = $bits(vec_t);
endpackage

// File: rtl/wm_vec_table.sv
module wm_vec_table
  import wm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  vec_t             wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output vec_t             rdata_o
);
  vec_t mem_q [NUM_VEC];

  for (genvar e = 0; e < NUM_VEC; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[e] <= '0;
      else if (we_i && waddr_i == IDX_W'(e))       mem_q[e] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/wm_ready_eval.sv
module wm_ready_eval
  import wm_pkg::*;
(
  input  logic [RDY_W-1:0] rdy_i,
  input  logic [RDY_W-1:0] mask_i,
  input  logic [RDY_W-1:0] pol_i,
  input  logic             comb_or_i,
  output logic             met_o
);
  logic [RDY_W-1:0] match;
  logic             any_hit, all_hit;

  always_comb begin
    match   = ~(rdy_i ^ pol_i) & mask_i;
    any_hit = |match;
    all_hit = (match == mask_i);
    if (mask_i == '0)   met_o = 1'b1;
    else if (comb_or_i) met_o = any_hit;
    else                met_o = all_hit;
  end
endmodule

// File: rtl/wm_seq.sv
module wm_seq
  import wm_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             met_i,
  input  logic             last_i,
  input  logic [IDX_W-1:0] next_i,
  input  logic [TO_W-1:0]  timeout_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             fire_o,
  output logic             done_o,
  output logic             err_o
);
  typedef enum logic {S_IDLE, S_RUN} st_t;

  st_t              st_q;
  logic [IDX_W-1:0] idx_q;
  logic [TO_W-1:0]  wcnt_q;
  logic             done_q, err_q, expire;

  assign busy_o = (st_q == S_RUN);
  assign fire_o = busy_o & met_i;
  assign expire = busy_o & ~met_i & (timeout_i != '0) & (wcnt_q == timeout_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      wcnt_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q   <= S_RUN;
          idx_q  <= '0;
          wcnt_q <= '0;
          err_q  <= 1'b0;
        end
        S_RUN: begin
          if (met_i) begin
            wcnt_q <= '0;
            if (last_i) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              idx_q <= next_i;
            end
          end else if (expire) begin
            st_q   <= S_IDLE;
            err_q  <= 1'b1;
            wcnt_q <= '0;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  // R7
  done_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R8
  err_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($past(busy_o) && !busy_o && !done_o));
  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !met_i && !expire) |=> (busy_o && $stable(idx_o)));
endmodule

// File: rtl/wave_master.sv
module wave_master
  import wm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TO_W   = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [14:0]       cfg_data_i,
  input  logic              start_i,
  input  logic              bus_16_i,
  input  logic [1:0]        fifo_sel_i,
  input  logic [ADDR_W-1:0] addr_base_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic [1:0]        rdy_i,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  input  logic [DATA_W-1:0] bus_din_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        ctl_o,
  output logic [1:0]        fifo_sel_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fifo_adv_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  output logic [DATA_W-1:0] bus_dout_o,
  output logic              bus_oe_o
);
  localparam int LANES = DATA_W / 8;

  vec_t             cur;
  logic [IDX_W-1:0] idx;
  logic             met, fire, busy, launch;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        sel_q;
  logic [DATA_W-1:0] lane_mask;

  wm_vec_table u_tab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_addr_i),
    .wdata_i (vec_t'(cfg_data_i)),
    .raddr_i (idx),
    .rdata_o (cur)
  );

  wm_ready_eval u_rdy (
    .rdy_i     (rdy_i),
    .mask_i    (cur.mask),
    .pol_i     (cur.pol),
    .comb_or_i (cur.comb_or),
    .met_o     (met)
  );

  wm_seq #(.TO_W(TO_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .met_i     (met),
    .last_i    (cur.last),
    .next_i    (cur.nxt),
    .timeout_i (timeout_i),
    .busy_o    (busy),
    .idx_o     (idx),
    .fire_o    (fire),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  assign launch = start_i & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      sel_q  <= '0;
    end else if (launch) begin
      addr_q <= addr_base_i;
      sel_q  <= fifo_sel_i;
    end else if (fire && cur.inc) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  // lane 0 always live; upper lanes only in wide mode
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_lo
      assign lane_mask[7:0] = 8'hFF;
    end else begin : g_hi
      assign lane_mask[l*8 +: 8] = {8{bus_16_i}};
    end
  end

  assign busy_o       = busy;
  assign ctl_o        = busy ? cur.ctl : '0;
  assign fifo_sel_o   = sel_q;
  assign addr_o       = addr_q;
  assign fifo_adv_o   = fire & cur.adv;
  assign bus_oe_o     = busy & cur.drive;
  assign bus_dout_o   = bus_oe_o ? (fifo_rdata_i & lane_mask) : '0;
  assign fifo_wdata_o = bus_din_i & lane_mask;

  // R3
  ctl_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ctl_o == '0));
  // R5
  adv_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_adv_o |-> busy_o);
  // R2
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(fifo_sel_o));
  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(fire && cur.inc)) |-> $stable(addr_o));
  // R6
  oe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> (bus_dout_o == '0));
endmodule

// File: tb/wave_master_test.sv
module wave_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int EV_ADV = 0, EV_DONE = 1, EV_ERR = 2;

  typedef struct {
    int          kind;
    logic [2:0]  ctl;
    logic [7:0]  addr;
    logic [15:0] data;
    string       req;
  } ev_t;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_addr = 0; logic [14:0] cfg_data = 0;
  logic start = 0, bus16 = 1; logic [1:0] fsel = 0; logic [7:0] abase = 0;
  logic [7:0] tmo = 0; logic [1:0] rdy = 0;
  logic [15:0] frd = 0, bdin = 0;
  logic busy_o, done_o, err_o, fifo_adv_o, bus_oe_o;
  logic [2:0] ctl_o; logic [1:0] fifo_sel_o; logic [7:0] addr_o;
  logic [15:0] fifo_wdata_o, bus_dout_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit err_prev = 0;
  ev_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_master uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .start_i(start), .bus_16_i(bus16), .fifo_sel_i(fsel),
    .addr_base_i(abase), .timeout_i(tmo), .rdy_i(rdy), .fifo_rdata_i(frd),
    .bus_din_i(bdin), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .ctl_o(ctl_o), .fifo_sel_o(fifo_sel_o), .addr_o(addr_o),
    .fifo_adv_o(fifo_adv_o), .fifo_wdata_o(fifo_wdata_o),
    .bus_dout_o(bus_dout_o), .bus_oe_o(bus_oe_o)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [14:0] mk(logic [2:0] ctl, logic [1:0] mask, logic [1:0] pol,
      bit orr, bit adv, bit inc, bit drv, bit last, logic [2:0] nxt);
    return {nxt, last, drv, inc, adv, orr, pol, mask, ctl};
  endfunction

  task automatic wr_vec(int i, logic [14:0] w);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(i); cfg_data = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic push(int kind, logic [2:0] ctl, logic [7:0] addr, logic [15:0] data, string req);
    ev_t e;
    e.kind = kind; e.ctl = ctl; e.addr = addr; e.data = data; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic take(int kind, logic [2:0] ctl, logic [7:0] addr, logic [15:0] data);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(0, "R7", "unexpected event kind", kind, 32'hFFFF);
      return;
    end
    e = exp_q.pop_front();
    chk(e.kind == kind, e.req, "event kind", kind, e.kind);
    if (kind == EV_ADV && e.kind == EV_ADV)
      chk(ctl == e.ctl && addr == e.addr && data == e.data, e.req, "adv ctl/addr/data",
          {5'd0, ctl, addr, data}, {5'd0, e.ctl, e.addr, e.data});
  endtask

  // monitor
  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (fifo_adv_o) take(EV_ADV, ctl_o, addr_o, bus_oe_o ? bus_dout_o : fifo_wdata_o);
      if (done_o) take(EV_DONE, 3'd0, 8'd0, 16'd0);
      if (err_o && !err_prev) take(EV_ERR, 3'd0, 8'd0, 16'd0);
      err_prev = err_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic load_p1();
    wr_vec(0, mk(3'b001, 2'b00, 2'b00, 0, 1, 1, 1, 0, 3'd1));
    wr_vec(1, mk(3'b110, 2'b01, 2'b01, 0, 1, 1, 1, 0, 3'd2));
    wr_vec(2, mk(3'b000, 2'b00, 2'b00, 0, 0, 0, 1, 1, 3'd0));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy_o && !done_o && !err_o && !fifo_adv_o && !bus_oe_o, "R1", "idle flags",
        {busy_o, done_o, err_o, fifo_adv_o, bus_oe_o}, 0);
    chk(ctl_o == 0 && fifo_sel_o == 0, "R1", "idle ctl/sel", {ctl_o, fifo_sel_o}, 0);
    rst_n = 1;
    load_p1();

    // T2: 16-bit drive, wait on rdy0, stray start and select change while waiting
    bus16 = 1; frd = 16'hA5C3; abase = 8'h10; fsel = 2'd2; rdy = 2'b00; tmo = 0;
    push(EV_ADV, 3'b001, 8'h10, 16'hA5C3, "R5");
    push(EV_ADV, 3'b110, 8'h11, 16'hA5C3, "R4");
    push(EV_DONE, 0, 0, 0, "R7");
    pulse_start();
    #2;
    chk(busy_o, "R2", "busy after start", busy_o, 1);
    chk(ctl_o == 3'b001, "R3", "ctl vec0", ctl_o, 3'b001);
    chk(bus_oe_o, "R6", "oe when driving", bus_oe_o, 1);
    @(negedge clk); #2;
    chk(ctl_o == 3'b110 && busy_o, "R4", "holding on unmet vec1", ctl_o, 3'b110);
    fsel = 2'd1; abase = 8'h77;
    pulse_start(); // R9 ignored
    #2;
    chk(fifo_sel_o == 2'd2, "R2", "select held", fifo_sel_o, 2'd2);
    chk(addr_o == 8'h11 && busy_o, "R9", "start ignored while busy", addr_o, 8'h11);
    @(negedge clk); rdy = 2'b01;
    wait_idle();
    chk(ctl_o == 0 && addr_o == 8'h12, "R5", "idle ctl, final addr", {ctl_o, addr_o}, {3'd0, 8'h12});

    // T3: 8-bit mode masks upper byte
    bus16 = 0; abase = 8'h40; rdy = 2'b01;
    push(EV_ADV, 3'b001, 8'h40, 16'h00C3, "R6");
    push(EV_ADV, 3'b110, 8'h41, 16'h00C3, "R6");
    push(EV_DONE, 0, 0, 0, "R7");
    pulse_start();
    wait_idle();

    // T4: AND / OR with polarity, jump chain 0->5->3, capture direction
    bus16 = 1; bdin = 16'h5A69; abase = 8'h20; rdy = 2'b01;
    wr_vec(0, mk(3'b010, 2'b11, 2'b11, 0, 1, 0, 0, 0, 3'd5));
    wr_vec(5, mk(3'b100, 2'b11, 2'b10, 1, 1, 1, 0, 0, 3'd3));
    wr_vec(3, mk(3'b111, 2'b00, 2'b00, 0, 1, 0, 0, 1, 3'd0));
    push(EV_ADV, 3'b010, 8'h20, 16'h5A69, "R4");
    push(EV_ADV, 3'b100, 8'h20, 16'h5A69, "R4");
    push(EV_ADV, 3'b111, 8'h21, 16'h5A69, "R7");
    push(EV_DONE, 0, 0, 0, "R7");
    pulse_start();
    @(negedge clk); #2;
    chk(ctl_o == 3'b010 && busy_o, "R4", "AND needs both", ctl_o, 3'b010);
    chk(!bus_oe_o && fifo_wdata_o == 16'h5A69, "R6", "capture path", {bus_oe_o, fifo_wdata_o}, {1'b0, 16'h5A69});
    @(negedge clk); rdy = 2'b11;
    @(negedge clk); rdy = 2'b01;
    @(negedge clk); #2;
    chk(ctl_o == 3'b100 && busy_o, "R4", "OR with no match holds", ctl_o, 3'b100);
    @(negedge clk); rdy = 2'b00;
    wait_idle();

    // T5: timeout boundary, satisfied on cycle timeout+1
    load_p1();
    bus16 = 1; abase = 8'h30; rdy = 2'b00; tmo = 8'd4;
    push(EV_ADV, 3'b001, 8'h30, 16'hA5C3, "R8");
    push(EV_ADV, 3'b110, 8'h31, 16'hA5C3, "R8");
    push(EV_DONE, 0, 0, 0, "R8");
    pulse_start();
    repeat (5) @(negedge clk);
    rdy = 2'b01;
    wait_idle();
    chk(!err_o, "R8", "no error at boundary", err_o, 0);

    // T6: never satisfied -> abort
    rdy = 2'b00; abase = 8'h50;
    push(EV_ADV, 3'b001, 8'h50, 16'hA5C3, "R8");
    push(EV_ERR, 0, 0, 0, "R8");
    pulse_start();
    wait_idle();
    chk(err_o && !busy_o && ctl_o == 0, "R8", "abort state", {err_o, busy_o}, 2'b10);

    // T7: next start clears error
    rdy = 2'b01;
    push(EV_ADV, 3'b001, 8'h50, 16'hA5C3, "R8");
    push(EV_ADV, 3'b110, 8'h51, 16'hA5C3, "R8");
    push(EV_DONE, 0, 0, 0, "R7");
    pulse_start();
    #2;
    chk(!err_o && busy_o, "R8", "error cleared by start", {err_o, busy_o}, 2'b01);
    wait_idle();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule